// File: doc/BRIEF.md
# Superframe Spare-Bit and CRC Checker

This block sits in the receive path of a line transceiver. Once per superframe it takes the spare overhead bits carried in the M channel and builds an 8-bit status byte from them. It also checks the 12-bit CRC sent by the far end against a CRC the block computes itself over the serial data of the superframe that has just ended. A mismatch is reported twice. It clears the near-end error flag in the status byte, and it forces the far-end error bit that the transmitter sends during the following superframe low.

The block works only while spare-bit processing is enabled and the line holds full superframe alignment. The completed byte is offered to an interrupt queue one cycle after the boundary strobe. If the queue reports full, the byte is dropped and a sticky overflow flag is raised. In the alternate interface mode, two external status pins are sampled into the top of the byte.

Top module: `spare_crc_check`

## Requirements
- R1: While `proc_en` is low, a boundary strobe produces no push and no overflow, and `tx_febe` returns to or stays at 1.
- R2: While `line_sync` is low, a boundary strobe produces no push and no overflow, and `tx_febe` returns to or stays at 1.
- R3: A strobe taken while active (`sf_strobe`, `proc_en` and `line_sync` all high) loads `stat_byte` with bit 5 = `rx_m51`, bit 4 = `rx_m61`, bit 3 = `rx_m52`, bit 2 = `rx_m62` (the received far-end error bit) and bit 0 = 0. The byte holds its value until the next active strobe.
- R4: The local CRC uses the generator x^12+x^11+x^3+x^2+x+1 (0x80F), shifted in MSB first. It covers only the bits for which `crc_valid` is high, from the cycle after one strobe through the cycle before the next strobe. A bit that arrives during a strobe cycle starts the next superframe. At an active strobe, bit 1 (NEB) of the byte is 0 if `far_crc` differs from the local CRC, and 1 otherwise.
- R5: `tx_febe` is 1 after reset. From the cycle after an active strobe it equals that strobe's NEB, and it holds until the next strobe.
- R6: With `alt_mode` high at an active strobe, bit 7 = `ext_b` and bit 6 = `ext_a`. With `alt_mode` low, both bits are 0.
- R7: `stat_push` is a one-cycle pulse in the cycle after an active strobe for which `queue_full` was low.
- R8: An active strobe with `queue_full` high produces no push and sets `ovf_flag`, which stays high until reset.
- R9: At the first active strobe after an inactive strobe (or after reset), no full superframe has been summed, so NEB is 1 whatever `far_crc` holds.
- R10: In reset, `stat_push`, `ovf_flag` and `stat_byte` are 0 and `tx_febe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sf_strobe | input | 1 | Superframe boundary, one cycle |
| line_sync | input | 1 | Line fully superframe-aligned |
| proc_en | input | 1 | Spare-bit processing enable |
| rx_m51 | input | 1 | Received spare bit M51 |
| rx_m52 | input | 1 | Received spare bit M52 |
| rx_m61 | input | 1 | Received spare bit M61 |
| rx_m62 | input | 1 | Received far-end block-error bit |
| far_crc | input | 12 | CRC received from the far end, valid at strobe |
| crc_bit | input | 1 | Serial data bit for the local CRC |
| crc_valid | input | 1 | Qualifies `crc_bit` |
| alt_mode | input | 1 | Alternate interface mode, samples external pins |
| ext_a | input | 1 | External status pin A |
| ext_b | input | 1 | External status pin B |
| queue_full | input | 1 | Interrupt queue cannot take a push |
| stat_byte | output | 8 | Status byte |
| stat_push | output | 1 | Push strobe to the interrupt queue |
| ovf_flag | output | 1 | Sticky: a push was dropped |
| tx_febe | output | 1 | Far-end error bit to transmit next superframe |

## Verification
The CRC compare is tried with superframes of several lengths and with random, sparse `crc_valid` patterns. The far CRC is either matching or off by one bit. This separates a correct generator and correct qualification from ones that differ only on some data. Strobes with `proc_en` or `line_sync` low, and the first strobe after regaining activity, separate gating from comparison. Strobes under a full queue and in alternate mode check the drop path and the pin sampling. A behavioural model is compared with every output on every cycle.

// File: rtl/scc_pkg.sv
// Package: shared constants and the overhead-bit bundle for the spare-bit checker.
// Assumes: a 12-bit far-end CRC and an 8-bit status byte.
package scc_pkg;
    localparam int STAT_W = 8;

    typedef struct packed {
        logic m51;
        logic m52;
        logic m61;
        logic m62;
    } ovh_t;
endpackage

// File: rtl/scc_crc_acc.sv
// Serial CRC accumulator, MSB-first, generator given by POLY.
// Restarts from zero on `restart`. A qualified bit in the restart cycle
// becomes the first bit of the new sum.
module scc_crc_acc #(
    parameter int          CRC_W = 12,
    parameter logic [11:0] POLY  = 12'h80F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             bit_valid,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_q
);
    logic [CRC_W-1:0] base;
    logic [CRC_W-1:0] stepped;
    logic             fb;

    // Purpose: choose the seed and advance by one bit.
    always_comb begin
        base    = restart ? '0 : crc_q;
        fb      = base[CRC_W-1] ^ bit_in;
        stepped = {base[CRC_W-2:0], 1'b0} ^ (fb ? POLY[CRC_W-1:0] : '0);
    end

    // Purpose: hold the running sum.
    always_ff @(posedge clk) begin
        if (!rst_n)         crc_q <= '0;
        else if (bit_valid) crc_q <= stepped;
        else if (restart)   crc_q <= '0;
    end
endmodule

// File: rtl/scc_compare.sv
// CRC comparison at the boundary. Produces NEB (1 = no error).
// Assumes: a compare counts only if the previous strobe was active, so the
// local sum spans one whole superframe.
module scc_compare #(
    parameter int CRC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic             active,
    input  logic [CRC_W-1:0] far_crc,
    input  logic [CRC_W-1:0] local_crc,
    output logic             neb
);
    logic spanned;

    // Purpose: remember whether the running superframe began at an active strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      spanned <= 1'b0;
        else if (strobe) spanned <= active;
    end

    // Purpose: flag a mismatch only over a full superframe.
    always_comb neb = !(spanned && (far_crc != local_crc));
endmodule

// File: rtl/scc_status_push.sv
// Builds the status byte and offers it to the interrupt queue.
// Assumes: a full queue drops the byte and raises a sticky overflow.
module scc_status_push
    import scc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  ovh_t              ovh,
    input  logic              neb,
    input  logic              alt_mode,
    input  logic              ext_a,
    input  logic              ext_b,
    input  logic              queue_full,
    output logic [STAT_W-1:0] stat_byte,
    output logic              stat_push,
    output logic              ovf_flag
);
    logic [STAT_W-1:0] next_byte;

    // Purpose: lay out the byte; the external pins count only in alternate mode.
    always_comb begin
        next_byte = {alt_mode & ext_b, alt_mode & ext_a, ovh.m51, ovh.m61,
                     ovh.m52, ovh.m62, neb, 1'b0};
    end

    // Purpose: register the byte, the push pulse and the sticky overflow.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_byte <= '0;
            stat_push <= 1'b0;
            ovf_flag  <= 1'b0;
        end else begin
            stat_push <= active && !queue_full;
            if (active)               stat_byte <= next_byte;
            if (active && queue_full) ovf_flag  <= 1'b1;
        end
    end
endmodule

// File: rtl/spare_crc_check.sv
// Top: superframe spare-bit capture and CRC check.
// Assumes: the spare bits, far_crc and the external pins are valid in the
// strobe cycle.
module spare_crc_check #(
    parameter int          CRC_W = 12,
    parameter logic [11:0] POLY  = 12'h80F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sf_strobe,
    input  logic             line_sync,
    input  logic             proc_en,
    input  logic             rx_m51,
    input  logic             rx_m52,
    input  logic             rx_m61,
    input  logic             rx_m62,
    input  logic [CRC_W-1:0] far_crc,
    input  logic             crc_bit,
    input  logic             crc_valid,
    input  logic             alt_mode,
    input  logic             ext_a,
    input  logic             ext_b,
    input  logic             queue_full,
    output logic [7:0]       stat_byte,
    output logic             stat_push,
    output logic             ovf_flag,
    output logic             tx_febe
);
    import scc_pkg::*;

    logic             active;
    logic             neb;
    logic [CRC_W-1:0] local_crc;
    ovh_t             ovh;

    // Purpose: qualify the boundary and bundle the spare bits.
    always_comb begin
        active = sf_strobe && proc_en && line_sync;
        ovh    = '{m51: rx_m51, m52: rx_m52, m61: rx_m61, m62: rx_m62};
    end

    scc_crc_acc #(.CRC_W(CRC_W), .POLY(POLY)) i_crc (
        .clk(clk), .rst_n(rst_n), .restart(sf_strobe),
        .bit_valid(crc_valid), .bit_in(crc_bit), .crc_q(local_crc)
    );

    scc_compare #(.CRC_W(CRC_W)) i_cmp (
        .clk(clk), .rst_n(rst_n), .strobe(sf_strobe), .active(active),
        .far_crc(far_crc), .local_crc(local_crc), .neb(neb)
    );

    scc_status_push i_stat (
        .clk(clk), .rst_n(rst_n), .active(active), .ovh(ovh), .neb(neb),
        .alt_mode(alt_mode), .ext_a(ext_a), .ext_b(ext_b),
        .queue_full(queue_full), .stat_byte(stat_byte),
        .stat_push(stat_push), .ovf_flag(ovf_flag)
    );

    // Purpose: error bit for the next transmitted superframe, held between strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_febe <= 1'b1;
        else if (sf_strobe) tx_febe <= active ? neb : 1'b1;
    end
endmodule

// File: rtl/scc_checker.sv
// Checker: temporal properties of the spare-bit checker at its ports.
module scc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sf_strobe,
    input logic       line_sync,
    input logic       proc_en,
    input logic       alt_mode,
    input logic       queue_full,
    input logic [7:0] stat_byte,
    input logic       stat_push,
    input logic       ovf_flag,
    input logic       tx_febe
);
    AST_PUSH_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        stat_push |-> $past(sf_strobe && proc_en && line_sync && !queue_full)); // R7

    AST_NO_PUSH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sf_strobe && !(proc_en && line_sync)) |=> !stat_push); // R1

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag); // R8

    AST_FEBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sf_strobe |=> $stable(tx_febe)); // R5

    AST_FEBE_MATCHES_NEB: assert property (@(posedge clk) disable iff (!rst_n)
        stat_push |-> (stat_byte[1] == tx_febe)); // R5

    AST_PINS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_push && !$past(alt_mode)) |-> (stat_byte[7:6] == 2'b00)); // R6

    AST_BIT0_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stat_push |-> !stat_byte[0]); // R3
endmodule

bind spare_crc_check scc_checker i_scc_checker (
    .clk(clk), .rst_n(rst_n), .sf_strobe(sf_strobe), .line_sync(line_sync),
    .proc_en(proc_en), .alt_mode(alt_mode), .queue_full(queue_full),
    .stat_byte(stat_byte), .stat_push(stat_push), .ovf_flag(ovf_flag),
    .tx_febe(tx_febe)
);

// File: tb/test_spare_crc_check.sv
// Bench: behavioural model compared with every output on every clock.
module test_spare_crc_check;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sf_strobe = 0, line_sync = 0, proc_en = 0;
    logic rx_m51 = 0, rx_m52 = 0, rx_m61 = 0, rx_m62 = 0;
    logic [11:0] far_crc = '0;
    logic crc_bit = 0, crc_valid = 0, alt_mode = 0, ext_a = 0, ext_b = 0;
    logic queue_full = 0;
    logic [7:0] stat_byte;
    logic stat_push, ovf_flag, tx_febe;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Model state
    int   m_run = 0;
    bit   m_span = 0;
    logic [7:0] m_byte = '0;
    bit   m_push = 0, m_ovf = 0, m_febe = 1;

    spare_crc_check i_spare_crc_check (
        .clk(clk), .rst_n(rst_n), .sf_strobe(sf_strobe), .line_sync(line_sync),
        .proc_en(proc_en), .rx_m51(rx_m51), .rx_m52(rx_m52), .rx_m61(rx_m61),
        .rx_m62(rx_m62), .far_crc(far_crc), .crc_bit(crc_bit),
        .crc_valid(crc_valid), .alt_mode(alt_mode), .ext_a(ext_a),
        .ext_b(ext_b), .queue_full(queue_full), .stat_byte(stat_byte),
        .stat_push(stat_push), .ovf_flag(ovf_flag), .tx_febe(tx_febe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int crc_next(int c, bit b);
        int fb;
        fb = ((c >> 11) & 1) ^ int'(b);
        c  = (c << 1) & 'hFFF;
        if (fb != 0) c = c ^ 'h80F;
        return c;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Model update with the inputs present at the edge.
    task automatic model_step();
        bit act, neb;
        if (!rst_n) begin
            m_run = 0; m_span = 0; m_byte = '0; m_push = 0; m_ovf = 0; m_febe = 1;
            return;
        end
        act = sf_strobe && proc_en && line_sync;
        neb = !(m_span && (int'(far_crc) != m_run));
        m_push = act && !queue_full;
        if (act && queue_full) m_ovf = 1;
        if (act) m_byte = {alt_mode & ext_b, alt_mode & ext_a, rx_m51, rx_m61,
                           rx_m52, rx_m62, neb, 1'b0};
        if (sf_strobe) begin
            m_febe = act ? neb : 1'b1;
            m_span = act;
            m_run  = crc_valid ? crc_next(0, crc_bit) : 0;
        end else if (crc_valid) begin
            m_run = crc_next(m_run, crc_bit);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk("R7 push", int'(stat_push), int'(m_push));
        chk("R3 byte", int'(stat_byte), int'(m_byte));
        chk("R5 febe", int'(tx_febe), int'(m_febe));
        chk("R8 ovf", int'(ovf_flag), int'(m_ovf));
    endtask

    // One superframe: len data cycles, then a strobe cycle.
    task automatic superframe(int len, bit bad, bit full, int dens);
        for (int i = 0; i < len; i++) begin
            crc_valid = (($urandom % 4) < dens);
            crc_bit   = $urandom % 2;
            cycle();
        end
        sf_strobe  = 1;
        {rx_m51, rx_m52, rx_m61, rx_m62} = 4'($urandom);
        {ext_a, ext_b} = 2'($urandom);
        far_crc    = 12'(bad ? (m_run ^ 1) : m_run);
        queue_full = full;
        crc_valid  = $urandom % 2;
        crc_bit    = $urandom % 2;
        cycle();
        sf_strobe = 0; queue_full = 0; crc_valid = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) cycle();
        chk("R10 reset push", int'(stat_push), 0);
        chk("R10 reset ovf", int'(ovf_flag), 0);
        chk("R10 reset febe", int'(tx_febe), 1);
        chk("R10 reset byte", int'(stat_byte), 0);
        rst_n = 1;
        proc_en = 1; line_sync = 1;

        // First strobe: no spanned superframe yet, so a bad CRC is not flagged.
        superframe(20, 1, 0, 3);
        chk("R9 first strobe neb", int'(stat_byte[1]), 1);
        // Good CRC over full superframes of several densities.
        superframe(37, 0, 0, 3);
        chk("R4 good neb", int'(stat_byte[1]), 1);
        superframe(64, 0, 0, 1);
        chk("R4 sparse good neb", int'(stat_byte[1]), 1);
        // Mismatch: NEB low, febe low for a whole superframe.
        superframe(50, 1, 0, 4);
        chk("R4 bad neb", int'(stat_byte[1]), 0);
        chk("R5 febe low", int'(tx_febe), 0);
        superframe(30, 0, 0, 2);
        chk("R5 febe recovers", int'(tx_febe), 1);
        // Alternate mode samples the pins.
        alt_mode = 1;
        superframe(25, 0, 0, 3);
        chk("R6 pins", int'(stat_byte[7:6]), int'({ext_b, ext_a}));
        superframe(25, 1, 0, 3);
        alt_mode = 0;
        superframe(25, 0, 0, 3);
        chk("R6 pins quiet", int'(stat_byte[7:6]), 0);
        // Disabled: no push, febe forced high.
        superframe(25, 1, 0, 3);
        proc_en = 0;
        superframe(25, 1, 0, 3);
        chk("R1 no push", int'(stat_push), 0);
        chk("R1 febe high", int'(tx_febe), 1);
        proc_en = 1;
        superframe(25, 1, 0, 3);
        chk("R9 after enable", int'(stat_byte[1]), 1);
        // Unsynced.
        line_sync = 0;
        superframe(25, 1, 0, 3);
        chk("R2 no push", int'(stat_push), 0);
        chk("R2 febe high", int'(tx_febe), 1);
        line_sync = 1;
        superframe(25, 0, 0, 3);
        // Full queue drops and sets a sticky overflow.
        superframe(25, 0, 1, 3);
        chk("R8 dropped", int'(stat_push), 0);
        chk("R8 ovf set", int'(ovf_flag), 1);
        superframe(25, 0, 0, 3);
        chk("R8 ovf sticky", int'(ovf_flag), 1);
        chk("R7 push after full", int'(stat_push), 1);
        repeat (4) cycle();
        chk("R7 single pulse", int'(stat_push), 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule